// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives the six gate signals of a three-phase bridge. A single 12-bit timebase is shared by all three phases. Each phase compares the count against its own duty value to form a raw high-side demand. A per-phase dead-band state machine turns that demand into a complementary high/low pair, and it holds both gates off for a programmable number of clock cycles around every hand-over. The timebase either ramps up and wraps (edge-aligned) or ramps up and back down (center-aligned). It raises a one-cycle period event at the start of every period, which can be used to start an analog-to-digital conversion.

Period, duties and alignment are double-buffered. Writes land in shadow registers and are taken over only at the period boundary, so a period never runs with a mix of old and new settings. Two trip inputs, one from an analog comparator and one from an external pin, act combinationally on the gates: all six go low in the same cycle that either trip is high. The trip also latches a fault flag. The gates stay off until software pulses the clear input while neither trip is active. After that the pairs restart through a full dead-time gap.

State machines. Timebase: `TB_IDLE` (disabled, count held at 0, shadows reloaded), `TB_UP` and `TB_DOWN`. Its transitions are IDLE→UP on enable; UP→UP with a wrap to 0 at the period value in edge mode; UP→DOWN at the period value in center mode; DOWN→UP when the count goes from 1 to 0; and any state→IDLE on disable. Dead-band, per phase: `DB_OFF`, `DB_GAP_HI`, `DB_HIGH`, `DB_GAP_LO` and `DB_LOW`. OFF goes to the gap toward the demanded side. LOW goes to GAP_HI when the demand rises, and HIGH goes to GAP_LO when it falls. A gap moves on to its target after the dead-time count. A gap falls back to the side it came from if the demand reverts before the count ends. A gap is skipped entirely when the dead time is 0. Any state goes to OFF while the block is disabled or blocked. Fault: `FL_CLEAR` and `FL_TRIPPED`. CLEAR goes to TRIPPED on either trip. TRIPPED goes to CLEAR on a clear pulse with both trips low.

Top module: `tri_phase_pwm`

## Requirements
- R1: In edge-aligned mode (`align_center`=0) the count runs 0,1,…,P and wraps, so one period lasts P+1 cycles. `period_evt` is high for exactly the one cycle in which the count is 0 at the start of each period.
- R2: In center-aligned mode (`align_center`=1, P≥1) the count runs 0,…,P,P-1,…,1, so one period lasts 2P cycles. The raw demand of a phase with duty D (1≤D≤P) is high for 2D-1 contiguous cycles. `period_evt` marks the count-0 cycle.
- R3: A phase's raw demand is high while count < its duty. Gates are active-high. With dead time T, every turn-on of either gate is delayed by T cycles, so per period the high gate is on (raw high time − T) cycles, the low gate is on (raw low time − T) cycles, and both are off 2T cycles. The two gates of a phase are never on together.
- R4: A raw high or low interval of length ≤ T never turns its gate on. The opposite gate resumes as soon as the demand reverts, so the phase spends exactly that interval with both gates off.
- R5: Duty 0 keeps the high gate off for the whole period. A duty greater than the period keeps the high gate on and the low gate off for the whole period.
- R6: Writes to `period`, `duty` and `align_center` take effect only at the next period boundary (the wrap in edge mode, the count-0 point in center mode). The period in progress finishes with its old length and duties.
- R7: While `trip_cmp` or `trip_ext` is high, all six gates are low in that same cycle.
- R8: A trip sets `fault_flag` at the next clock edge. The flag, and with it all-gates-off, holds until a clock edge where `fault_clr`=1 and both trips are low. After the flag clears, the gates stay off for one cycle plus T cycles, and then each phase has exactly one gate on.
- R9: With `enable`=0 all gates are low in the same cycle, the count returns to 0 and no `period_evt` is raised. After `enable` rises, `period_evt` appears in the next cycle.
- R10: During and directly after reset all gates, `period_evt` and `fault_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the timebase and gates |
| align_center | input | 1 | 0 = edge-aligned, 1 = center-aligned (buffered) |
| period | input | CNT_W | Period value P (buffered) |
| duty | input | NPH*CNT_W | Duty per phase, phase i at bits i*CNT_W +: CNT_W (buffered) |
| dead_time | input | DT_W | Dead time T in clock cycles |
| trip_cmp | input | 1 | Comparator trip, active high |
| trip_ext | input | 1 | External-pin trip, active high |
| fault_clr | input | 1 | Request to clear the fault flag |
| gate_hi | output | NPH | High-side gates, bit i = phase i |
| gate_lo | output | NPH | Low-side gates, bit i = phase i |
| period_evt | output | 1 | One-cycle start-of-period event |
| fault_flag | output | 1 | Latched fault |

## Verification
The bench measures whole periods between two period events and tallies high, low and both-off cycles per phase. An off-by-one in the dead-time counter or in the center-mode turnaround therefore shows up as a wrong tally or a wrong period length. It goes after pulses no longer than the dead time, where a design that forgot to fall back from the gap would either emit a sliver of a pulse or leave both gates off for too long. It also covers duty 0 and duty above the period, where a wrong compare gives a one-cycle glitch. It rewrites the duties and period in the middle of a period; a design without double-buffering would shorten or stretch that period. It raises a trip while a pair is active, and clears the flag while the other trip is still held. A registered trip path would leak one cycle of drive. A flag that cleared too eagerly would re-arm the gates into a live fault.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;

    typedef enum logic [1:0] {
        TB_IDLE = 2'd0,
        TB_UP   = 2'd1,
        TB_DOWN = 2'd2
    } tb_state_t;

    typedef enum logic [2:0] {
        DB_OFF    = 3'd0,
        DB_GAP_HI = 3'd1,
        DB_HIGH   = 3'd2,
        DB_GAP_LO = 3'd3,
        DB_LOW    = 3'd4
    } db_state_t;

    typedef enum logic {
        FL_CLEAR   = 1'b0,
        FL_TRIPPED = 1'b1
    } fl_state_t;

    typedef enum logic {
        ALIGN_EDGE   = 1'b0,
        ALIGN_CENTER = 1'b1
    } align_t;

endpackage

// File: rtl/tpwm_timebase.sv
module tpwm_timebase
    import tpwm_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int NPH   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 align_i,
    input  logic [CNT_W-1:0]     period_i,
    input  logic [NPH*CNT_W-1:0] duty_i,
    output logic [CNT_W-1:0]     cnt_o,
    output logic [NPH*CNT_W-1:0] duty_act_o,
    output logic                 active_o,
    output logic                 evt_o
);

    tb_state_t            st_q, st_nx;
    logic [CNT_W-1:0]     cnt_q, cnt_nx;
    logic [CNT_W-1:0]     per_act_q;
    logic [NPH*CNT_W-1:0] duty_act_q;
    align_t               mode_act_q;
    logic                 load;
    logic                 evt_q;

    // next-state and count
    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        load   = 1'b0;
        unique case (st_q)
            TB_IDLE: begin
                cnt_nx = '0;
                load   = 1'b1;
                st_nx  = TB_UP;
            end
            TB_UP: begin
                if (cnt_q >= per_act_q) begin
                    if (mode_act_q == ALIGN_EDGE || per_act_q <= 1) begin
                        cnt_nx = '0;
                        load   = 1'b1;
                    end else begin
                        cnt_nx = cnt_q - 1'b1;
                        st_nx  = TB_DOWN;
                    end
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            TB_DOWN: begin
                if (cnt_q <= 1) begin
                    cnt_nx = '0;
                    st_nx  = TB_UP;
                    load   = 1'b1;
                end else begin
                    cnt_nx = cnt_q - 1'b1;
                end
            end
            default: begin
                st_nx  = TB_IDLE;
                cnt_nx = '0;
            end
        endcase
        if (!run) begin
            st_nx  = TB_IDLE;
            cnt_nx = '0;
            load   = 1'b0;
        end
    end

    // state register with shadow take-over at the boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= TB_IDLE;
            cnt_q      <= '0;
            per_act_q  <= '0;
            duty_act_q <= '0;
            mode_act_q <= ALIGN_EDGE;
            evt_q      <= 1'b0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
            evt_q <= load;
            if (load) begin
                per_act_q  <= period_i;
                duty_act_q <= duty_i;
                mode_act_q <= align_t'(align_i);
            end
        end
    end

    // outputs
    always_comb begin
        cnt_o      = cnt_q;
        duty_act_o = duty_act_q;
        active_o   = (st_q != TB_IDLE);
        evt_o      = evt_q;
    end

endmodule

// File: rtl/tpwm_deadband.sv
module tpwm_deadband
    import tpwm_pkg::*;
#(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            raw,
    input  logic [DT_W-1:0] dead_i,
    output logic            hi_o,
    output logic            lo_o
);

    db_state_t       st_q, st_nx;
    logic [DT_W-1:0] dcnt_q, dcnt_nx;
    logic            no_gap;

    assign no_gap = (dead_i == '0);

    always_comb begin
        st_nx   = st_q;
        dcnt_nx = dcnt_q;
        unique case (st_q)
            DB_OFF: begin
                dcnt_nx = dead_i;
                if (raw) st_nx = no_gap ? DB_HIGH : DB_GAP_HI;
                else     st_nx = no_gap ? DB_LOW  : DB_GAP_LO;
            end
            DB_GAP_HI: begin
                if (!raw)              st_nx = DB_LOW;
                else if (dcnt_q <= 1)  st_nx = DB_HIGH;
                else                   dcnt_nx = dcnt_q - 1'b1;
            end
            DB_HIGH: begin
                if (!raw) begin
                    st_nx   = no_gap ? DB_LOW : DB_GAP_LO;
                    dcnt_nx = dead_i;
                end
            end
            DB_GAP_LO: begin
                if (raw)               st_nx = DB_HIGH;
                else if (dcnt_q <= 1)  st_nx = DB_LOW;
                else                   dcnt_nx = dcnt_q - 1'b1;
            end
            DB_LOW: begin
                if (raw) begin
                    st_nx   = no_gap ? DB_HIGH : DB_GAP_HI;
                    dcnt_nx = dead_i;
                end
            end
            default: st_nx = DB_OFF;
        endcase
        if (!run) st_nx = DB_OFF;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= DB_OFF;
            dcnt_q <= '0;
        end else begin
            st_q   <= st_nx;
            dcnt_q <= dcnt_nx;
        end
    end

    always_comb begin
        hi_o = (st_q == DB_HIGH);
        lo_o = (st_q == DB_LOW);
    end

endmodule

// File: rtl/tpwm_fault.sv
module tpwm_fault
    import tpwm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trip_a,
    input  logic trip_b,
    input  logic clr,
    output logic block_o,
    output logic flag_o
);

    fl_state_t st_q, st_nx;
    logic      trip;

    assign trip = trip_a | trip_b;

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FL_CLEAR:   if (trip)         st_nx = FL_TRIPPED;
            FL_TRIPPED: if (clr && !trip) st_nx = FL_CLEAR;
            default:                      st_nx = FL_TRIPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FL_CLEAR;
        else        st_q <= st_nx;
    end

    // trip acts combinationally, the latched state keeps it
    always_comb begin
        flag_o  = (st_q == FL_TRIPPED);
        block_o = trip | flag_o;
    end

endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm
    import tpwm_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int NPH   = 3,
    parameter int DT_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic                 align_center,
    input  logic [CNT_W-1:0]     period,
    input  logic [NPH*CNT_W-1:0] duty,
    input  logic [DT_W-1:0]      dead_time,
    input  logic                 trip_cmp,
    input  logic                 trip_ext,
    input  logic                 fault_clr,
    output logic [NPH-1:0]       gate_hi,
    output logic [NPH-1:0]       gate_lo,
    output logic                 period_evt,
    output logic                 fault_flag
);

    localparam int DUTY_W = NPH * CNT_W;

    logic [CNT_W-1:0]  cnt;
    logic [DUTY_W-1:0] duty_act;
    logic              tb_active;
    logic              block;
    logic              pair_run;
    logic [NPH-1:0]    raw;
    logic [NPH-1:0]    db_hi, db_lo;

    tpwm_timebase #(.CNT_W(CNT_W), .NPH(NPH)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (enable),
        .align_i    (align_center),
        .period_i   (period),
        .duty_i     (duty),
        .cnt_o      (cnt),
        .duty_act_o (duty_act),
        .active_o   (tb_active),
        .evt_o      (period_evt)
    );

    tpwm_fault u_flt (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip_a  (trip_cmp),
        .trip_b  (trip_ext),
        .clr     (fault_clr),
        .block_o (block),
        .flag_o  (fault_flag)
    );

    assign pair_run = enable & ~block;

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        assign raw[i] = tb_active && (cnt < duty_act[i*CNT_W +: CNT_W]);

        tpwm_deadband #(.DT_W(DT_W)) u_db (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (pair_run),
            .raw    (raw[i]),
            .dead_i (dead_time),
            .hi_o   (db_hi[i]),
            .lo_o   (db_lo[i])
        );
    end

    // same-cycle kill path
    assign gate_hi = db_hi & {NPH{pair_run}};
    assign gate_lo = db_lo & {NPH{pair_run}};

endmodule

// File: rtl/tpwm_checker.sv
module tpwm_checker #(
    parameter int NPH  = 3,
    parameter int DT_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            enable,
    input logic            trip_cmp,
    input logic            trip_ext,
    input logic            fault_clr,
    input logic [DT_W-1:0] dead_time,
    input logic [NPH-1:0]  gate_hi,
    input logic [NPH-1:0]  gate_lo,
    input logic            fault_flag
);

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0); // R3

    AST_HI_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_time != '0 && $stable(dead_time)) |->
        ((gate_hi & ~$past(gate_hi) & $past(gate_lo)) == '0)); // R3

    AST_LO_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dead_time != '0 && $stable(dead_time)) |->
        ((gate_lo & ~$past(gate_lo) & $past(gate_hi)) == '0)); // R3

    AST_TRIP_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_cmp || trip_ext) |-> (gate_hi | gate_lo) == '0); // R7

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_cmp || trip_ext) |=> fault_flag); // R8

    AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_flag && !fault_clr) |=> fault_flag); // R8

    AST_FLAG_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> (gate_hi | gate_lo) == '0); // R8

    AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (gate_hi | gate_lo) == '0); // R9

endmodule

bind tri_phase_pwm tpwm_checker #(.NPH(NPH), .DT_W(DT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .trip_cmp   (trip_cmp),
    .trip_ext   (trip_ext),
    .fault_clr  (fault_clr),
    .dead_time  (dead_time),
    .gate_hi    (gate_hi),
    .gate_lo    (gate_lo),
    .fault_flag (fault_flag)
);

// File: tb/tri_phase_pwm_tb.sv
module tri_phase_pwm_tb;

    localparam int CNT_W = 12;
    localparam int NPH   = 3;
    localparam int DT_W  = 8;

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 enable;
    logic                 align_center;
    logic [CNT_W-1:0]     period;
    logic [NPH*CNT_W-1:0] duty;
    logic [DT_W-1:0]      dead_time;
    logic                 trip_cmp;
    logic                 trip_ext;
    logic                 fault_clr;
    logic [NPH-1:0]       gate_hi;
    logic [NPH-1:0]       gate_lo;
    logic                 period_evt;
    logic                 fault_flag;

    int n_tests = 0;
    int n_fail  = 0;
    int m_len, m_ovl;
    int m_hi [NPH];
    int m_lo [NPH];
    int m_off[NPH];

    always #2 clk = ~clk;

    tri_phase_pwm #(.CNT_W(CNT_W), .NPH(NPH), .DT_W(DT_W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .align_center (align_center),
        .period       (period),
        .duty         (duty),
        .dead_time    (dead_time),
        .trip_cmp     (trip_cmp),
        .trip_ext     (trip_ext),
        .fault_clr    (fault_clr),
        .gate_hi      (gate_hi),
        .gate_lo      (gate_lo),
        .period_evt   (period_evt),
        .fault_flag   (fault_flag)
    );

    // columns: mode, P, D (all phases), T, exp_hi, exp_lo, exp_off, exp_len
    localparam int NROW = 10;
    localparam int TBL [NROW][8] = '{
        '{0,  9,  4, 0,  4,  6, 0, 10},
        '{0,  9,  4, 2,  2,  4, 4, 10},
        '{0, 19, 10, 3,  7,  7, 6, 20},
        '{0,  9,  0, 2,  0, 10, 0, 10},
        '{0,  9, 12, 2, 10,  0, 0, 10},
        '{0,  9,  2, 3,  0,  8, 2, 10},
        '{1,  8,  4, 0,  7,  9, 0, 16},
        '{1,  8,  4, 2,  5,  7, 4, 16},
        '{1, 10,  1, 0,  1, 19, 0, 20},
        '{1,  6,  7, 1, 12,  0, 0, 12}
    };

    function automatic string row_tag(input int r);
        case (r)
            3, 4:    return "R5";
            5:       return "R4";
            6, 7, 8, 9: return "R2";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic configure(input int mode, input int p, input int d0, input int d1,
                             input int d2, input int t);
        @(negedge clk);
        enable = 1'b0;
        repeat (2) @(negedge clk);
        align_center = mode[0];
        period       = CNT_W'(p);
        duty         = {CNT_W'(d2), CNT_W'(d1), CNT_W'(d0)};
        dead_time    = DT_W'(t);
        enable       = 1'b1;
    endtask

    task automatic sync_evt();
        int guard = 0;
        @(negedge clk);
        while (!period_evt && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // tally from the current (event) cycle up to, not including, the next event
    task automatic tally_to_evt();
        m_len = 0;
        m_ovl = 0;
        for (int i = 0; i < NPH; i++) begin
            m_hi[i] = 0; m_lo[i] = 0; m_off[i] = 0;
        end
        do begin
            for (int i = 0; i < NPH; i++) begin
                if (gate_hi[i] && gate_lo[i]) m_ovl++;
                else if (gate_hi[i])          m_hi[i]++;
                else if (gate_lo[i])          m_lo[i]++;
                else                          m_off[i]++;
            end
            m_len++;
            @(negedge clk);
        end while (!period_evt && m_len < 5000);
    endtask

    task automatic measure();
        sync_evt();
        tally_to_evt();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; align_center = 1'b0;
        period = '0; duty = '0; dead_time = '0;
        trip_cmp = 1'b0; trip_ext = 1'b0; fault_clr = 1'b0;

        // R10 reset state
        repeat (3) @(negedge clk);
        chk("R10", "gates in reset", int'({gate_hi, gate_lo}), 0);
        chk("R10", "evt in reset", int'(period_evt), 0);
        chk("R10", "flag in reset", int'(fault_flag), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "gates after reset", int'({gate_hi, gate_lo}), 0);
        chk("R9", "no evt while disabled", int'(period_evt), 0);

        // table of configurations
        for (int r = 0; r < NROW; r++) begin
            configure(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][2], TBL[r][2], TBL[r][3]);
            measure();
            measure();
            chk(TBL[r][0] == 0 ? "R1" : "R2", $sformatf("row %0d period length", r), m_len, TBL[r][7]);
            chk("R3", $sformatf("row %0d overlap", r), m_ovl, 0);
            for (int i = 0; i < NPH; i++) begin
                chk(row_tag(r), $sformatf("row %0d ph%0d hi", r, i), m_hi[i], TBL[r][4]);
                chk(row_tag(r), $sformatf("row %0d ph%0d lo", r, i), m_lo[i], TBL[r][5]);
                chk(row_tag(r), $sformatf("row %0d ph%0d off", r, i), m_off[i], TBL[r][6]);
            end
        end

        // R3 distinct duties per phase
        configure(0, 9, 2, 5, 9, 0);
        measure();
        measure();
        chk("R3", "ph0 hi distinct duty", m_hi[0], 2);
        chk("R3", "ph1 hi distinct duty", m_hi[1], 5);
        chk("R3", "ph2 hi distinct duty", m_hi[2], 9);

        // R6 double buffering
        configure(0, 9, 4, 4, 4, 0);
        measure();
        sync_evt();
        duty   = {CNT_W'(7), CNT_W'(7), CNT_W'(7)};
        period = CNT_W'(14);
        tally_to_evt();
        chk("R6", "old period kept", m_len, 10);
        chk("R6", "old duty kept", m_hi[0], 4);
        tally_to_evt();
        chk("R6", "new period length", m_len, 15);
        chk("R6", "new duty hi", m_hi[1], 7);
        chk("R6", "new duty lo", m_lo[2], 8);

        // R7 / R8 comparator trip
        configure(0, 9, 5, 5, 5, 1);
        measure();
        repeat (2) @(negedge clk);
        trip_cmp = 1'b1;
        #1;
        chk("R7", "cmp trip same cycle", int'({gate_hi, gate_lo}), 0);
        @(negedge clk);
        chk("R8", "flag set", int'(fault_flag), 1);
        trip_cmp = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8", "gates held off", int'({gate_hi, gate_lo}), 0);
        chk("R8", "flag held", int'(fault_flag), 1);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk("R8", "flag cleared", int'(fault_flag), 0);
        chk("R8", "off first cycle after clear", int'({gate_hi, gate_lo}), 0);
        @(negedge clk);
        chk("R8", "off during restart gap", int'({gate_hi, gate_lo}), 0);
        @(negedge clk);
        chk("R8", "one gate per phase after restart", $countones({gate_hi, gate_lo}), 3);
        measure();
        chk("R8", "hi after recovery", m_hi[0], 4);

        // R7 / R8 external trip, clear refused while held
        repeat (3) @(negedge clk);
        trip_ext = 1'b1;
        #1;
        chk("R7", "ext trip same cycle", int'({gate_hi, gate_lo}), 0);
        @(negedge clk);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk("R8", "clear refused during trip", int'(fault_flag), 1);
        trip_ext = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8", "still off after trip drops", int'({gate_hi, gate_lo}), 0);
        fault_clr = 1'b1;
        @(negedge clk);
        fault_clr = 1'b0;
        chk("R8", "flag cleared after ext", int'(fault_flag), 0);

        // R9 disable mid-run and restart
        measure();
        repeat (3) @(negedge clk);
        enable = 1'b0;
        #1;
        chk("R9", "gates off on disable", int'({gate_hi, gate_lo}), 0);
        begin
            int evts = 0;
            repeat (20) begin
                @(negedge clk);
                if (period_evt) evts++;
            end
            chk("R9", "no evt while disabled", evts, 0);
        end
        enable = 1'b1;
        @(negedge clk);
        chk("R9", "evt one cycle after enable", int'(period_evt), 1);
        @(negedge clk);
        chk("R1", "evt is one cycle wide", int'(period_evt), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule